// File: doc/BRIEF.md
# Sparse Position Map Encoder

The encoder turns a stream of nonzero matrix coordinates into a dense bit-level map of where the nonzeros are. Coordinates arrive one per handshake on a valid/ready port. They must be in row-major order, and the last one of a matrix carries an end marker. The row and column counts of the matrix come from two configuration inputs. Each coordinate is folded into one linear position, `row * cols + col`. The gap from the previous nonzero becomes a zero-run field, and the nonzero itself becomes a single set bit.

A zero-run field is self-sizing. It is a four-bit header followed by just enough four-bit count groups to hold the run length. The fields are packed back to back into fixed-width output words, with no alignment padding. After the end marker, any zeros that remain up to the end of the matrix are closed off as one more run. Then a final word is sent carrying a last flag and the number of meaningful bits in it.

The nonzero values themselves travel on a separate path. A coordinate that does not move strictly forward is discarded, and a sticky error output is raised.

Top module: `bve_encoder`

## Requirements
- R1: Each accepted nonzero adds exactly one `1` bit to the stream, and two nonzeros at adjacent positions produce no field between their bits.
- R2: A gap of G>0 zeros is written as a `0` bit, then a 3-bit field (most significant bit first) equal to N-1, then G as N four-bit groups. The groups go most significant first, each group most significant bit first. N is the smallest count in 1..8 for which G fits in 4N bits.
- R3: The first stream bit goes to bit 0 of an output word and later bits fill upward. Fields continue across word boundaries with no padding. Every non-final word reports 32 valid bits with the last flag low.
- R4: The linear position of an input is `row * cols + col`. The gap before a nonzero is the number of positions between it and the previous kept nonzero, or from position 0 for the first one.
- R5: After the coordinate flagged as last, the positions from just past the last kept nonzero to `rows * cols - 1` are emitted as one more zero-run field, when that range is not empty.
- R6: The final word of a matrix has the last flag high and reports its 1..32 remaining bits. If the trailing run is empty and the stream already ends on a word boundary, an extra final word with 0 valid bits and data 0 is sent.
- R7: A coordinate whose linear position is not above that of the previous kept nonzero adds no bits to the stream. It sets the error output, which stays high until reset.
- R8: Once the final word of a matrix has been sent, the next coordinate starts a new matrix at position 0.
- R9: Out of reset the output valid and error outputs are low and the input is ready.
- R10: The input is held not ready while 32 or more bits are waiting to be sent. No bit is lost or repeated under this flow control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rows | input | ROW_W | Matrix row count |
| cfg_cols | input | COL_W | Matrix column count |
| in_valid | input | 1 | Coordinate valid |
| in_ready | output | 1 | Coordinate accepted when high with in_valid |
| in_row | input | ROW_W | Row of the nonzero |
| in_col | input | COL_W | Column of the nonzero |
| in_last | input | 1 | Marks the last coordinate of the matrix |
| out_valid | output | 1 | Output word valid (one cycle) |
| out_word | output | WORD_W | Packed stream bits, first bit at bit 0 |
| out_last | output | 1 | Final word of the matrix |
| out_nbits | output | $clog2(WORD_W+1) | Number of valid bits in out_word |
| err_order | output | 1 | Sticky out-of-order coordinate flag |

## Verification
The bench builds the encoder with 16-bit row and column fields and 32-bit words. With those widths, one coordinate in a 65535 by 65535 matrix is enough to need all eight count groups (header field value 7). The resulting 37-bit field also crosses a word boundary. The 32-bit word width lets short hand-built matrices land exactly on a word edge, both with and without a trailing run, so both forms of the final word are reached. Long runs of two-group fields keep the staging register above one word for many cycles, which holds the input back.

// File: rtl/bve_pkg.sv
package bve_pkg;
  localparam int HDR_W   = 4;
  localparam int NIB_MAX = 8;
  localparam int CNT_W   = 4 * NIB_MAX;
  localparam int SYM_W   = HDR_W + CNT_W + 1;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_TAIL  = 2'd1,
    ST_FLUSH = 2'd2
  } bve_state_e;
endpackage

// File: rtl/bve_position.sv
module bve_position #(
  parameter int ROW_W = 16,
  parameter int COL_W = 16,
  localparam int POS_W = ROW_W + COL_W
) (
  input  logic [ROW_W-1:0] cfg_rows,
  input  logic [COL_W-1:0] cfg_cols,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  input  logic [POS_W-1:0] next_pos,
  output logic [POS_W-1:0] lin_pos,
  output logic [POS_W-1:0] gap,
  output logic [POS_W-1:0] tail_gap,
  output logic             backward
);
  logic [POS_W-1:0] total;

  always_comb begin
    lin_pos  = POS_W'(in_row) * POS_W'(cfg_cols) + POS_W'(in_col);
    total    = POS_W'(cfg_rows) * POS_W'(cfg_cols);
    backward = lin_pos < next_pos;
    gap      = lin_pos - next_pos;
    tail_gap = total - next_pos;
  end
endmodule

// File: rtl/bve_symbol.sv
module bve_symbol
  import bve_pkg::*;
#(
  parameter int POS_W = 32,
  localparam int LEN_W = $clog2(SYM_W + 1)
) (
  input  logic [POS_W-1:0] run,
  input  logic             with_one,
  output logic [SYM_W-1:0] sym_bits,
  output logic [LEN_W-1:0] sym_len
);
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] aligned;
  logic [2:0]       nm1;
  int               nib;

  always_comb begin
    cnt_w = CNT_W'(run);
    nib   = 1;
    for (int k = 1; k < NIB_MAX; k++) begin
      if ((cnt_w >> (4 * k)) != '0) nib = k + 1;
    end
    nm1      = 3'(nib - 1);
    aligned  = cnt_w << (CNT_W - 4 * nib);
    sym_bits = '0;
    sym_len  = '0;
    if (run != '0) begin
      sym_bits[0] = 1'b0;
      sym_bits[1] = nm1[2];
      sym_bits[2] = nm1[1];
      sym_bits[3] = nm1[0];
      for (int k = 0; k < CNT_W; k++) begin
        if (k < 4 * nib) sym_bits[HDR_W + k] = aligned[CNT_W - 1 - k];
      end
      sym_len = LEN_W'(HDR_W + 4 * nib);
    end
    if (with_one) begin
      sym_bits = sym_bits | (SYM_W'(1) << sym_len);
      sym_len  = sym_len + LEN_W'(1);
    end
  end
endmodule

// File: rtl/bve_packer.sv
module bve_packer
  import bve_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int LEN_W  = $clog2(SYM_W + 1),
  localparam int BUF_W  = WORD_W - 1 + SYM_W,
  localparam int FILL_W = $clog2(BUF_W + 1),
  localparam int NB_W   = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              append,
  input  logic [SYM_W-1:0]  app_bits,
  input  logic [LEN_W-1:0]  app_len,
  input  logic              emit,
  input  logic              emit_last,
  output logic [FILL_W-1:0] fill,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last,
  output logic [NB_W-1:0]   out_nbits
);
  localparam logic [FILL_W-1:0] WORD_F = FILL_W'(WORD_W);

  logic [BUF_W-1:0]  sr_q, sr_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              ov_q, ov_d, last_q, last_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [NB_W-1:0]   nb_q, nb_d;
  logic              sr_en;

  always_comb begin
    sr_d   = sr_q;
    fill_d = fill_q;
    sr_en  = emit | append;
    if (emit) begin
      sr_d   = sr_q >> WORD_W;
      fill_d = (fill_q > WORD_F) ? fill_q - WORD_F : '0;
    end else if (append) begin
      sr_d   = sr_q | (BUF_W'(app_bits) << fill_q);
      fill_d = fill_q + FILL_W'(app_len);
    end
    ov_d   = emit;
    last_d = emit & emit_last;
    word_d = sr_q[WORD_W-1:0];
    nb_d   = (fill_q >= WORD_F) ? NB_W'(WORD_W) : NB_W'(fill_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
      ov_q   <= 1'b0;
      last_q <= 1'b0;
      word_q <= '0;
      nb_q   <= '0;
    end else begin
      if (sr_en) begin
        sr_q   <= sr_d;
        fill_q <= fill_d;
      end
      ov_q   <= ov_d;
      last_q <= last_d;
      if (emit) begin
        word_q <= word_d;
        nb_q   <= nb_d;
      end
    end
  end

  assign fill      = fill_q;
  assign out_valid = ov_q;
  assign out_word  = word_q;
  assign out_last  = last_q;
  assign out_nbits = nb_q;

  // R10: new bits only enter while less than a word is staged, never with a drain
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    append |-> (fill_q < WORD_F) && !emit);
  // R3: every word other than the final one is completely filled
  p_full_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (out_nbits == NB_W'(WORD_W)));
endmodule

// File: rtl/bve_encoder.sv
module bve_encoder
  import bve_pkg::*;
#(
  parameter int ROW_W  = 16,
  parameter int COL_W  = 16,
  parameter int WORD_W = 32,
  localparam int POS_W  = ROW_W + COL_W,
  localparam int LEN_W  = $clog2(SYM_W + 1),
  localparam int BUF_W  = WORD_W - 1 + SYM_W,
  localparam int FILL_W = $clog2(BUF_W + 1),
  localparam int NB_W   = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  cfg_rows,
  input  logic [COL_W-1:0]  cfg_cols,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  input  logic              in_last,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last,
  output logic [NB_W-1:0]   out_nbits,
  output logic              err_order
);
  localparam logic [FILL_W-1:0] WORD_F = FILL_W'(WORD_W);

  logic [1:0]        rst_pipe_q;
  logic              rst_s_n;
  bve_state_e        state_q, state_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic              pos_en;
  logic              err_q, err_d;
  logic [POS_W-1:0]  lin_pos, gap, tail_gap, sym_run;
  logic              backward, accept, sym_one;
  logic              append, emit, emit_last;
  logic [SYM_W-1:0]  sym_bits;
  logic [LEN_W-1:0]  sym_len;
  logic [FILL_W-1:0] fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  bve_position #(.ROW_W(ROW_W), .COL_W(COL_W)) u_pos (
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .in_row(in_row), .in_col(in_col),
    .next_pos(pos_q), .lin_pos(lin_pos), .gap(gap), .tail_gap(tail_gap),
    .backward(backward)
  );

  bve_symbol #(.POS_W(POS_W)) u_sym (
    .run(sym_run), .with_one(sym_one), .sym_bits(sym_bits), .sym_len(sym_len)
  );

  bve_packer #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_s_n), .append(append), .app_bits(sym_bits),
    .app_len(sym_len), .emit(emit), .emit_last(emit_last), .fill(fill),
    .out_valid(out_valid), .out_word(out_word), .out_last(out_last),
    .out_nbits(out_nbits)
  );

  always_comb begin
    state_d   = state_q;
    pos_d     = pos_q;
    pos_en    = 1'b0;
    err_d     = err_q;
    in_ready  = (state_q == ST_RUN) && (fill < WORD_F);
    accept    = in_valid && in_ready;
    sym_one   = (state_q == ST_RUN);
    sym_run   = (state_q == ST_RUN) ? gap : tail_gap;
    append    = 1'b0;
    emit      = 1'b0;
    emit_last = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        emit = (fill >= WORD_F);
        if (accept) begin
          if (backward) begin
            err_d = 1'b1;
          end else begin
            append = 1'b1;
            pos_d  = lin_pos + POS_W'(1);
            pos_en = 1'b1;
          end
          if (in_last) state_d = ST_TAIL;
        end
      end
      ST_TAIL: begin
        if (fill >= WORD_F) begin
          emit = 1'b1;
        end else begin
          append  = 1'b1;
          state_d = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        emit      = 1'b1;
        emit_last = (fill <= WORD_F);
        if (emit_last) begin
          state_d = ST_RUN;
          pos_d   = '0;
          pos_en  = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_RUN;
      pos_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (pos_en) pos_q <= pos_d;
    end
  end

  assign err_order = err_q;

  // R7: the ordering error never clears on its own
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_q |=> err_q);
  // R4: a kept coordinate always advances the position
  p_forward_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (accept && !backward) |=> (pos_q > $past(pos_q)));
  // R8: the final word restarts the position count
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (emit && emit_last) |=> (pos_q == '0) && (state_q == ST_RUN));
  // R10: no coordinate is taken while a whole word waits
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fill >= WORD_F) |-> !in_ready);
endmodule

// File: tb/sim_bve_encoder.sv
module sim_bve_encoder;
  localparam int ROW_W = 16, COL_W = 16, WORD_W = 32;
  localparam int NB_W = $clog2(WORD_W + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic [ROW_W-1:0] cfg_rows;
  logic [COL_W-1:0] cfg_cols;
  logic in_valid, in_ready, in_last;
  logic [ROW_W-1:0] in_row;
  logic [COL_W-1:0] in_col;
  logic out_valid, out_last, err_order;
  logic [WORD_W-1:0] out_word;
  logic [NB_W-1:0] out_nbits;

  always #10 clk = ~clk;

  bve_encoder #(.ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
    .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row), .in_col(in_col),
    .in_last(in_last), .out_valid(out_valid), .out_word(out_word),
    .out_last(out_last), .out_nbits(out_nbits), .err_order(err_order)
  );

  int checks = 0, fails = 0, stalls = 0;
  bit exp_err = 0;
  bit exp_q[$];
  int cr[$], cc[$];
  logic [31:0] gw[$];
  int gn[$];
  bit gl[$];

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      gw.push_back(out_word);
      gn.push_back(int'(out_nbits));
      gl.push_back(out_last);
    end
    if (in_valid && !in_ready) stalls++;
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic m_run(longint unsigned run);
    int n = 1;
    for (int k = 1; k < 8; k++) if ((run >> (4 * k)) != 0) n = k + 1;
    exp_q.push_back(1'b0);
    for (int b = 2; b >= 0; b--) exp_q.push_back(bit'(((n - 1) >> b) & 1));
    for (int b = 4 * n - 1; b >= 0; b--) exp_q.push_back(bit'((run >> b) & 1));
  endtask

  task automatic run_matrix(int rows, int cols, string req);
    longint unsigned npos = 0, lin, total;
    bit tail_empty;
    int nb, nw;
    exp_q.delete(); gw.delete(); gn.delete(); gl.delete();
    total = longint'(rows) * longint'(cols);
    foreach (cr[i]) begin
      lin = longint'(cr[i]) * longint'(cols) + longint'(cc[i]);
      if (lin < npos) exp_err = 1;
      else begin
        if (lin > npos) m_run(lin - npos);
        exp_q.push_back(1'b1);
        npos = lin + 1;
      end
    end
    tail_empty = (total == npos);
    if (!tail_empty) m_run(total - npos);
    cfg_rows = ROW_W'(rows);
    cfg_cols = COL_W'(cols);
    foreach (cr[i]) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_row = ROW_W'(cr[i]);
      in_col = COL_W'(cc[i]);
      in_last = (i == cr.size() - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last = 1'b0;
    for (int t = 0; t < 4000; t++) begin
      if (gl.size() > 0 && gl[gl.size() - 1]) break;
      @(negedge clk);
    end
    @(negedge clk);
    nb = exp_q.size();
    if (nb % 32 != 0 || tail_empty) nw = nb / 32 + 1;
    else nw = nb / 32;
    chk(req, "word count", gw.size(), nw);
    for (int w = 0; w < nw && w < gw.size(); w++) begin
      logic [31:0] ew;
      int en;
      ew = '0;
      en = nb - w * 32;
      if (en > 32) en = 32;
      for (int b = 0; b < en; b++) ew[b] = exp_q[w * 32 + b];
      chk(req, "word", gw[w], ew);
      chk(req, "nbits", gn[w], en);
      chk(req, "last", gl[w], (w == nw - 1));
    end
    chk(req, "error flag", err_order, exp_err);
  endtask

  task automatic add(int r, int c);
    cr.push_back(r);
    cc.push_back(c);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9", "out_valid", out_valid, 0);
    chk("R9", "err_order", err_order, 0);
    chk("R9", "in_ready", in_ready, 1);
  endtask

  task automatic t_dense();
    cr.delete(); cc.delete();
    for (int r = 0; r < 3; r++) for (int c = 0; c < 4; c++) add(r, c);
    run_matrix(3, 4, "R1");
    chk("R1", "hand word", gw[0], 32'hFFF);
    chk("R1", "hand nbits", gn[0], 12);
  endtask

  task automatic t_single_run();
    cr.delete(); cc.delete();
    add(0, 5);
    run_matrix(1, 6, "R2");
    chk("R2", "hand word", gw[0], 32'h1A0);
    chk("R2", "hand nbits", gn[0], 9);
  endtask

  task automatic t_two_nibble();
    cr.delete(); cc.delete();
    add(0, 16);
    run_matrix(1, 20, "R2");
  endtask

  task automatic t_wide_run();
    cr.delete(); cc.delete();
    add(65534, 65534);
    run_matrix(65535, 65535, "R2");
    chk("R2", "hand word0", gw[0], 32'h0007FFFE);
    chk("R3", "hand word1", gw[1], 32'h10);
    chk("R6", "hand nbits1", gn[1], 5);
  endtask

  task automatic t_mixed();
    cr.delete(); cc.delete();
    add(0, 0); add(0, 2); add(1, 0); add(1, 1); add(2, 2);
    add(2, 3); add(3, 0); add(3, 1); add(3, 3);
    run_matrix(4, 4, "R4");
  endtask

  task automatic t_tail();
    cr.delete(); cc.delete();
    add(1, 3);
    run_matrix(5, 7, "R5");
  endtask

  task automatic t_span();
    cr.delete(); cc.delete();
    for (int p = 0; p < 72; p++) if (p % 3 != 1 && p % 11 != 4) add(p / 9, p % 9);
    run_matrix(8, 9, "R3");
  endtask

  task automatic t_edge_empty();
    cr.delete(); cc.delete();
    for (int c = 0; c < 32; c++) add(0, c);
    run_matrix(1, 32, "R6");
    chk("R6", "hand full word", gw[0], 32'hFFFFFFFF);
    chk("R6", "hand empty nbits", gn[1], 0);
    chk("R6", "hand empty word", gw[1], 0);
  endtask

  task automatic t_edge_tail();
    cr.delete(); cc.delete();
    for (int c = 0; c < 24; c++) add(0, c);
    run_matrix(1, 27, "R6");
    chk("R6", "hand word", gw[0], 32'hC0FFFFFF);
    chk("R6", "hand last", gl[0], 1);
  endtask

  task automatic t_pressure();
    cr.delete(); cc.delete();
    stalls = 0;
    for (int p = 16; p < 4096; p += 17) add(p / 64, p % 64);
    run_matrix(64, 64, "R10");
    chk("R10", "input held back", (stalls > 0), 1);
  endtask

  task automatic t_order();
    cr.delete(); cc.delete();
    add(0, 1); add(0, 1); add(0, 0); add(2, 2);
    run_matrix(3, 3, "R7");
    chk("R7", "error set", err_order, 1);
  endtask

  task automatic t_restart();
    cr.delete(); cc.delete();
    add(0, 0);
    run_matrix(2, 2, "R8");
    chk("R7", "error still set", err_order, 1);
  endtask

  initial begin
    #(20ns * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_last = 1'b0; in_row = '0; in_col = '0;
    cfg_rows = '0; cfg_cols = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_dense();
    t_single_run();
    t_two_nibble();
    t_wide_run();
    t_mixed();
    t_tail();
    t_span();
    t_edge_empty();
    t_edge_tail();
    t_pressure();
    t_order();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule